// File: doc/BRIEF.md
# Bridge Pin-Mode and Slave-Select Controller

This block sits behind the byte-stream front end of a serial-bus-to-SPI bridge. It controls a small set of dual-use pins. Each pin is either an active-low SPI slave-select output or a quasi-bidirectional general-purpose pin. Each write message arrives as a start strobe, a run of byte strobes and a stop strobe. The first byte of a message is a function code.

Code F6h takes the next byte as a pin-mode mask. Code F5h copies the current pin levels into a one-byte holding buffer. Pin levels are never returned directly. A later single-byte buffer read drains the held byte, and the buffer is then invalid until the next F5h. Messages with any other code are handed unchanged to a side port for other logic.

In GPIO mode, the quasi-bidirectional behaviour is expressed as a strong-low enable plus a weak-high indication. The level driven comes from a per-pin latch value that other logic supplies. The pin levels read back pass through a synchronizer before any capture.

Top module: `ssgpio_ctl`

## Requirements
- R1: After reset, no pin is in GPIO mode. With no select requested, every pin drives strong high, none drives low and none is weak high. A buffer read returns 00h.
- R2: For a message whose first byte is F6h, the second byte's bits [N_PINS-1:0] become the mode mask (1 = GPIO, 0 = slave select), effective the cycle after that byte.
- R3: An F6h message that ends before its data byte leaves the mode mask unchanged. Bytes after the first data byte are ignored.
- R4: A pin in slave-select mode drives low while its ss_sel bit is 1 and drives strong high otherwise. A pin in GPIO mode ignores ss_sel.
- R5: A pin in GPIO mode drives low when its gpio_lat bit is 0 and shows weak high when it is 1. It never drives strong high.
- R6: A message whose first byte is F5h captures the synchronized pin levels (SYNC_STAGES flops behind pin_in) into the buffer. Bit i holds pin i if it is in GPIO mode and 0 otherwise, and bits above N_PINS are 0.
- R7: A rd_req pulse yields rd_valid one cycle later, with rd_data equal to the captured byte if the buffer is valid.
- R8: After a read, the buffer is invalid. Further reads return 00h until the next F5h capture.
- R9: Messages with any other first byte are forwarded byte by byte on fwd_valid/fwd_data one cycle after arrival. fwd_stop follows their stop strobe. The mode mask and buffer are unchanged.
- R10: Bytes that arrive outside a message (after a stop and before the next start) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_start | input | 1 | Write-message start strobe |
| msg_stop | input | 1 | Write-message stop strobe |
| byte_valid | input | 1 | Byte strobe for byte_data |
| byte_data | input | 8 | Message byte |
| rd_req | input | 1 | Single-byte buffer read request |
| rd_data | output | 8 | Byte returned for a read |
| rd_valid | output | 1 | rd_data valid strobe |
| fwd_valid | output | 1 | Forwarded byte strobe |
| fwd_data | output | 8 | Forwarded byte |
| fwd_stop | output | 1 | End of a forwarded message |
| ss_sel | input | N_PINS | Slave-select requests from the SPI side, 1 = select |
| gpio_lat | input | N_PINS | GPIO output latch values |
| pin_in | input | N_PINS | Sensed pin levels (asynchronous) |
| pin_drive_low | output | N_PINS | Strong pull-low enable per pin |
| pin_drive_high | output | N_PINS | Strong drive-high enable per pin |
| pin_weak_high | output | N_PINS | Weak pull-up only, pin readable |

## Verification
The assertions assume that the front end never raises msg_start, msg_stop and byte_valid in the same cycle. They also assume that a read request does not land in the same cycle as an F5h capture, because the buffer would then be both drained and refilled. The bench drives one strobe per cycle on the falling edge, with at least one idle cycle between them. It issues reads only after an F5h message has fully closed. Pin levels are held steady for several cycles before each capture, so the synchronizer delay never affects the expected byte.

// File: rtl/ssgpio_pkg.sv
package ssgpio_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FN_PIN_SNAP = 8'hF5;
  localparam logic [BYTE_W-1:0] FN_PIN_MODE = 8'hF6;

  typedef enum logic [2:0] {
    ST_OUTSIDE,
    ST_CODE,
    ST_MODE_DATA,
    ST_DISCARD,
    ST_FORWARD
  } msg_state_e;

  // Captured byte: GPIO pins keep their level, everything else reads 0.
  function automatic logic [BYTE_W-1:0] snap_byte(input logic [BYTE_W-1:0] lvl,
                                                  input logic [BYTE_W-1:0] mode);
    return lvl & mode;
  endfunction

  // Strong low: GPIO pin with latch 0, or selected slave-select pin.
  function automatic logic pull_low(input logic is_gpio, input logic lat, input logic sel);
    return is_gpio ? ~lat : sel;
  endfunction

  function automatic logic push_high(input logic is_gpio, input logic sel);
    return ~is_gpio & ~sel;
  endfunction

  function automatic logic weak_up(input logic is_gpio, input logic lat);
    return is_gpio & lat;
  endfunction
endpackage

// File: rtl/ssgpio_msg_decode.sv
module ssgpio_msg_decode
  import ssgpio_pkg::*;
#(
  parameter int N_PINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_start,
  input  logic              msg_stop,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              mode_load,
  output logic [N_PINS-1:0] mode_value,
  output logic              snap_req,
  output logic              fwd_valid,
  output logic [BYTE_W-1:0] fwd_data,
  output logic              fwd_stop
);
  msg_state_e st_q;
  logic       byte_ok;
  logic       is_foreign;

  assign byte_ok    = byte_valid & ~msg_start & ~msg_stop;
  assign is_foreign = (byte_data != FN_PIN_SNAP) && (byte_data != FN_PIN_MODE);
  assign mode_load  = byte_ok && (st_q == ST_MODE_DATA);
  assign mode_value = byte_data[N_PINS-1:0];
  assign snap_req   = byte_ok && (st_q == ST_CODE) && (byte_data == FN_PIN_SNAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_OUTSIDE;
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
      fwd_stop  <= 1'b0;
    end else begin
      fwd_valid <= byte_ok && ((st_q == ST_FORWARD) || ((st_q == ST_CODE) && is_foreign));
      fwd_stop  <= msg_stop && (st_q == ST_FORWARD);
      if (byte_ok) fwd_data <= byte_data;
      if (msg_stop) begin
        st_q <= ST_OUTSIDE;
      end else if (msg_start) begin
        st_q <= ST_CODE;
      end else if (byte_ok) begin
        unique case (st_q)
          ST_CODE: begin
            if (byte_data == FN_PIN_MODE)      st_q <= ST_MODE_DATA;
            else if (byte_data == FN_PIN_SNAP) st_q <= ST_DISCARD;
            else                               st_q <= ST_FORWARD;
          end
          ST_MODE_DATA: st_q <= ST_DISCARD;
          default:      st_q <= st_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/ssgpio_pin_ctl.sv
module ssgpio_pin_ctl
  import ssgpio_pkg::*;
#(
  parameter int N_PINS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [N_PINS-1:0] mode_value,
  input  logic [N_PINS-1:0] ss_sel,
  input  logic [N_PINS-1:0] gpio_lat,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] gpio_en,
  output logic [N_PINS-1:0] pin_sync,
  output logic [N_PINS-1:0] pin_drive_low,
  output logic [N_PINS-1:0] pin_drive_high,
  output logic [N_PINS-1:0] pin_weak_high
);
  logic [N_PINS-1:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gpio_en <= '0;
    else if (mode_load) gpio_en <= mode_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pin_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_sync = sync_q[SYNC_STAGES-1];

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign pin_drive_low[p]  = pull_low(gpio_en[p], gpio_lat[p], ss_sel[p]);
    assign pin_drive_high[p] = push_high(gpio_en[p], ss_sel[p]);
    assign pin_weak_high[p]  = weak_up(gpio_en[p], gpio_lat[p]);
  end
endmodule

// File: rtl/ssgpio_snap_buf.sv
module ssgpio_snap_buf
  import ssgpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_req,
  input  logic [BYTE_W-1:0] snap_data,
  input  logic              rd_req,
  output logic              buf_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [BYTE_W-1:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '0;
      buf_valid <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= buf_valid ? buf_q : '0;
      if (snap_req) begin
        buf_q     <= snap_data;
        buf_valid <= 1'b1;
      end else if (rd_req) begin
        buf_q     <= '0;
        buf_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssgpio_ctl.sv
module ssgpio_ctl
  import ssgpio_pkg::*;
#(
  parameter int N_PINS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_start,
  input  logic              msg_stop,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              rd_req,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              fwd_valid,
  output logic [7:0]        fwd_data,
  output logic              fwd_stop,
  input  logic [N_PINS-1:0] ss_sel,
  input  logic [N_PINS-1:0] gpio_lat,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_drive_low,
  output logic [N_PINS-1:0] pin_drive_high,
  output logic [N_PINS-1:0] pin_weak_high
);
  localparam int PAD_W = BYTE_W - N_PINS;

  logic              mode_load;
  logic [N_PINS-1:0] mode_value;
  logic              snap_req;
  logic [N_PINS-1:0] gpio_en;
  logic [N_PINS-1:0] pin_sync;
  logic [BYTE_W-1:0] cap_byte;
  logic              buf_valid;

  assign cap_byte = snap_byte({{PAD_W{1'b0}}, pin_sync}, {{PAD_W{1'b0}}, gpio_en});

  ssgpio_msg_decode #(.N_PINS(N_PINS)) u_dec (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_stop(msg_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .mode_load(mode_load),
    .mode_value(mode_value), .snap_req(snap_req), .fwd_valid(fwd_valid),
    .fwd_data(fwd_data), .fwd_stop(fwd_stop)
  );

  ssgpio_pin_ctl #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_value(mode_value),
    .ss_sel(ss_sel), .gpio_lat(gpio_lat), .pin_in(pin_in), .gpio_en(gpio_en),
    .pin_sync(pin_sync), .pin_drive_low(pin_drive_low),
    .pin_drive_high(pin_drive_high), .pin_weak_high(pin_weak_high)
  );

  ssgpio_snap_buf u_buf (
    .clk(clk), .rst_n(rst_n), .snap_req(snap_req), .snap_data(cap_byte),
    .rd_req(rd_req), .buf_valid(buf_valid), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/ssgpio_ctl_chk.sv
module ssgpio_ctl_chk #(
  parameter int N_PINS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_load,
  input logic [N_PINS-1:0] mode_value,
  input logic [N_PINS-1:0] gpio_en,
  input logic              snap_req,
  input logic              buf_valid,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic              byte_valid,
  input logic              fwd_valid,
  input logic [N_PINS-1:0] ss_sel,
  input logic [N_PINS-1:0] pin_drive_low,
  input logic [N_PINS-1:0] pin_drive_high,
  input logic [N_PINS-1:0] pin_weak_high
);
  p_drive_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_drive_low & pin_drive_high) == '0) &&
    ((pin_weak_high & (pin_drive_low | pin_drive_high)) == '0));

  p_ss_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~gpio_en & ~ss_sel & ~pin_drive_high) == '0));

  p_gpio_no_strong_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_en & pin_drive_high) == '0));

  p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (gpio_en == $past(mode_value)));

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_load |=> $stable(gpio_en));

  p_snap_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> buf_valid);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_data >> N_PINS) == 8'h00));

  p_rd_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !snap_req) |=> !buf_valid);

  p_invalid_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !buf_valid) |=> (rd_data == 8'h00));

  p_fwd_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(byte_valid));
endmodule

bind ssgpio_ctl ssgpio_ctl_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_value(mode_value),
  .gpio_en(gpio_en), .snap_req(snap_req), .buf_valid(buf_valid),
  .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
  .byte_valid(byte_valid), .fwd_valid(fwd_valid), .ss_sel(ss_sel),
  .pin_drive_low(pin_drive_low), .pin_drive_high(pin_drive_high),
  .pin_weak_high(pin_weak_high)
);

// File: tb/ssgpio_ctl_bench.sv
module ssgpio_ctl_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 8;
  // {mode mask, pin levels, expected captured byte}
  localparam logic [15:0] VEC [NV] = '{
    16'hFA0A, 16'h0F00, 16'h5F05, 16'hAF0A,
    16'hF000, 16'hC604, 16'h3501, 16'h9F09
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_start = 0, msg_stop = 0, byte_valid = 0, rd_req = 0;
  logic [7:0] byte_data = '0;
  logic [7:0] rd_data, fwd_data;
  logic rd_valid, fwd_valid, fwd_stop;
  logic [3:0] ss_sel = '0, gpio_lat = '0, pin_in = '0;
  logic [3:0] pin_drive_low, pin_drive_high, pin_weak_high;

  int n_chk = 0, n_fail = 0;
  logic       got_v, got_stop;
  logic [7:0] got_d;

  always #(CLK_P/2) clk = ~clk;

  ssgpio_ctl u_ssgpio_ctl (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_stop(msg_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .fwd_valid(fwd_valid),
    .fwd_data(fwd_data), .fwd_stop(fwd_stop), .ss_sel(ss_sel),
    .gpio_lat(gpio_lat), .pin_in(pin_in), .pin_drive_low(pin_drive_low),
    .pin_drive_high(pin_drive_high), .pin_weak_high(pin_weak_high)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic m_start();
    msg_start = 1; @(negedge clk); msg_start = 0; @(negedge clk);
  endtask

  task automatic m_stop();
    msg_stop = 1; @(negedge clk);
    got_stop = fwd_stop; msg_stop = 0; @(negedge clk);
    got_stop = got_stop | fwd_stop;
  endtask

  task automatic m_byte(input logic [7:0] b);
    byte_valid = 1; byte_data = b; @(negedge clk);
    got_v = fwd_valid; got_d = fwd_data; byte_valid = 0; @(negedge clk);
  endtask

  task automatic do_read(output logic v, output logic [7:0] d);
    rd_req = 1; @(negedge clk);
    v = rd_valid; d = rd_data; rd_req = 0; @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    m_start(); m_byte(8'hF6); m_byte({4'h0, m}); m_stop();
  endtask

  task automatic snap();
    m_start(); m_byte(8'hF5); m_stop();
  endtask

  task automatic chk_pins(input string tag, input logic [3:0] lo, input logic [3:0] hi,
                          input logic [3:0] wk);
    chk({tag, " low"},  {4'h0, pin_drive_low},  {4'h0, lo});
    chk({tag, " high"}, {4'h0, pin_drive_high}, {4'h0, hi});
    chk({tag, " weak"}, {4'h0, pin_weak_high},  {4'h0, wk});
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic       v;
    logic [7:0] d;
    idle(3); rst_n = 1; idle(2);

    // R1: reset state
    chk_pins("R1 reset", 4'h0, 4'hF, 4'h0);
    do_read(v, d);
    chk("R1 rd_valid", {7'h0, v}, 8'h01);
    chk("R1 empty read", d, 8'h00);

    // R6 R7 R8: capture table
    for (int i = 0; i < NV; i++) begin
      set_mode(VEC[i][15:12]);
      pin_in = VEC[i][11:8];
      idle(4);
      snap();
      do_read(v, d);
      chk("R7 rd_valid", {7'h0, v}, 8'h01);
      chk("R6 captured byte", d, VEC[i][7:0]);
      do_read(v, d);
      chk("R8 drained read", d, 8'h00);
    end

    // R2 R4: mask 0101, no latch high, no select
    set_mode(4'h5); ss_sel = 4'h0; gpio_lat = 4'h0; idle(1);
    chk_pins("R2 mode 5", 4'h5, 4'hA, 4'h0);
    ss_sel = 4'hF; gpio_lat = 4'hF; idle(1);
    chk_pins("R4 select gated", 4'hA, 4'h0, 4'h5);
    // R5: quasi-bidirectional
    ss_sel = 4'h0; gpio_lat = 4'h4; idle(1);
    chk_pins("R5 latch 4", 4'h1, 4'hA, 4'h4);

    // R3: truncated mode message
    m_start(); m_byte(8'hF6); m_stop();
    chk_pins("R3 truncated", 4'h1, 4'hA, 4'h4);
    // R3: extra bytes ignored
    m_start(); m_byte(8'hF6); m_byte(8'h0F); m_byte(8'h00); m_byte(8'h03); m_stop();
    chk_pins("R3 extra bytes", 4'hB, 4'h0, 4'h4);

    // R9: foreign code forwarded
    m_start();
    m_byte(8'h42);
    chk("R9 fwd code valid", {7'h0, got_v}, 8'h01);
    chk("R9 fwd code", got_d, 8'h42);
    m_byte(8'hF6);
    chk("R9 fwd byte valid", {7'h0, got_v}, 8'h01);
    chk("R9 fwd byte", got_d, 8'hF6);
    m_byte(8'h00);
    m_stop();
    chk("R9 fwd stop", {7'h0, got_stop}, 8'h01);
    chk_pins("R9 mode kept", 4'hB, 4'h0, 4'h4);
    do_read(v, d);
    chk("R9 buffer untouched", d, 8'h00);
    // R9: own codes not forwarded
    m_start(); m_byte(8'hF5);
    chk("R9 no fwd own code", {7'h0, got_v}, 8'h00);
    m_stop();
    do_read(v, d);

    // R10: bytes outside a message
    m_byte(8'hF6); m_byte(8'h00); m_byte(8'hF5);
    chk("R10 no fwd outside", {7'h0, got_v}, 8'h00);
    chk_pins("R10 mode kept", 4'hB, 4'h0, 4'h4);
    do_read(v, d);
    chk("R10 no capture", d, 8'h00);

    // R6: capture held after a mode change, pin levels not re-sampled
    set_mode(4'hF); pin_in = 4'h6; idle(4); snap();
    pin_in = 4'h9; set_mode(4'h1); idle(4);
    do_read(v, d);
    chk("R6 held capture", d, 8'h06);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule